// File: doc/BRIEF.md
# Lane-Parallel Vector Arithmetic Unit

This block is a 256-bit vector arithmetic stage that splits each operand into eight independent 32-bit lanes. One operation is issued per clock through a flat request interface: an operation code, two vector operands, a 32-bit modulus, a 5-bit shift count with a direction bit, an element-size select and a valid strobe. The unit answers with a registered 256-bit vector and a matching valid flag one cycle later.

The unit offers lane-wise wrapping addition and subtraction, lane-wise addition and subtraction reduced by a modulus, and a lane-wise logical shift. It also has two interleave operations that build a result from alternate elements of the two source vectors, with elements of 32, 64 or 128 bits. These serve the butterfly and reordering steps of lattice transforms. Carries and borrows never cross a lane boundary. To keep switching activity low while masked data is processed, every operand the current operation does not read is forced to zero before it reaches the datapath. When no request is presented, all operands are forced to zero.

Top module: `vec_lane_alu`

## Requirements
- R1: While reset is asserted and after its release with no request, `out_valid_o` is 0 and `res_o` is all zeros.
- R2: Operation code 0 (wrapping add) gives, in every 32-bit lane i (bits 32i+31..32i), (A_i + B_i) mod 2^32. A carry out of one lane never reaches the next.
- R3: Operation code 1 (wrapping subtract) gives, in every lane, (A_i − B_i) mod 2^32. A borrow never leaves its lane.
- R4: Operation code 2 (modular add) forms the 33-bit sum A_i + B_i in each lane and subtracts the modulus once if the sum is greater than or equal to it. For inputs below the modulus, the lane result is therefore below the modulus.
- R5: Operation code 3 (modular subtract) forms A_i − B_i in each lane and adds the modulus once if A_i < B_i. For inputs below the modulus, the lane result is below the modulus.
- R6: Operation code 4 (shift) shifts every lane of A by the same 5-bit count. A direction bit of 1 gives a logical right shift and 0 gives a left shift. Operand B and the modulus do not affect the result.
- R7: Operation code 5 (even interleave) splits A and B into elements of the selected size. Result element 2k is A element 2k, and result element 2k+1 is B element 2k.
- R8: Operation code 6 (odd interleave) works the same way with the odd elements. Result element 2k is A element 2k+1, and result element 2k+1 is B element 2k+1.
- R9: The element-size select encodes 0 as 32-bit elements, 1 as 64-bit elements, and 2 or 3 as 128-bit elements. Only the interleave operations use it.
- R10: A request accepted at a clock edge sets `out_valid_o` for exactly the following cycle, with its result on `res_o`. With no request, `out_valid_o` is 0 and `res_o` holds its last value. Operation code 7 returns an all-zero vector.
- R11: Every operand input that the current operation does not read reaches the datapath as zero. With no request, all operands reach the datapath as zero. Values on unread inputs never change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..7) |
| opa_i | input | 256 | Vector operand A |
| opb_i | input | 256 | Vector operand B |
| mod_i | input | 32 | Modulus for modular operations |
| shamt_i | input | 5 | Shift count |
| shr_i | input | 1 | Shift direction, 1 = logical right |
| esz_i | input | 2 | Interleave element size select |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 256 | Result vector |

## Verification
The hardest case to reach is a modular add in which the 33-bit lane sum exceeds 2^32 while the modulus lies just below 2^32. Only the carry bit then decides whether the reduction happens. Uniformly random moduli almost never produce this case, so directed requests set the modulus to 0xFFFFFFFB with operands just below it. A second directed case places an all-ones lane next to a lane of small values, which shows that no carry or borrow crosses the lane boundary. The zero-forcing of unread inputs cannot be seen from the ports, so a bound checker watches it directly. The bench covers the same behaviour from outside by driving random garbage onto every unread input and comparing against the reference model.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int DEF_LANE_W = 32;
  localparam int DEF_LANES  = 8;
  localparam int NUM_ESZ    = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDM = 3'd2,
    OP_SUBM = 3'd3,
    OP_SHV  = 3'd4,
    OP_TRN1 = 3'd5,
    OP_TRN2 = 3'd6,
    OP_NONE = 3'd7
  } vop_e;
endpackage

// File: rtl/vla_operand_gate.sv
module vla_operand_gate
  import vla_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 32,
  parameter int SH_W   = 5
) (
  input  logic              valid_i,
  input  vop_e              op_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic [LANE_W-1:0] q_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              shr_i,
  input  logic [1:0]        esz_i,
  output logic [VEC_W-1:0]  a_o,
  output logic [VEC_W-1:0]  b_o,
  output logic [LANE_W-1:0] q_o,
  output logic [SH_W-1:0]   sh_o,
  output logic              shr_o,
  output logic [1:0]        esz_o
);
  logic use_a, use_b, use_q, use_sh, use_esz;

  always_comb begin
    use_a   = valid_i && (op_i != OP_NONE);
    use_b   = valid_i && (op_i inside {OP_ADD, OP_SUB, OP_ADDM, OP_SUBM, OP_TRN1, OP_TRN2});
    use_q   = valid_i && (op_i inside {OP_ADDM, OP_SUBM});
    use_sh  = valid_i && (op_i == OP_SHV);
    use_esz = valid_i && (op_i inside {OP_TRN1, OP_TRN2});
  end

  assign a_o   = use_a   ? a_i   : '0;
  assign b_o   = use_b   ? b_i   : '0;
  assign q_o   = use_q   ? q_i   : '0;
  assign sh_o  = use_sh  ? sh_i  : '0;
  assign shr_o = use_sh  ? shr_i : 1'b0;
  assign esz_o = use_esz ? esz_i : 2'b00;
endmodule

// File: rtl/vla_lane_arith.sv
module vla_lane_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] msum_o,
  output logic [W-1:0] mdiff_o
);
  function automatic logic [W-1:0] mod_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] q);
    logic [W:0] s;
    logic [W:0] r;
    s = {1'b0, a} + {1'b0, b};
    r = (s >= {1'b0, q}) ? (s - {1'b0, q}) : s;
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] mod_sub(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] q);
    logic [W-1:0] d;
    d = a - b;
    return (a < b) ? (d + q) : d;
  endfunction

  assign sum_o   = a_i + b_i;
  assign diff_o  = a_i - b_i;
  assign msum_o  = mod_add(a_i, b_i, q_i);
  assign mdiff_o = mod_sub(a_i, b_i, q_i);
endmodule

// File: rtl/vla_lane_shift.sv
module vla_lane_shift #(
  parameter int LANE_W = 32,
  parameter int LANES  = 8,
  parameter int SH_W   = 5
) (
  input  logic [LANE_W*LANES-1:0] a_i,
  input  logic [SH_W-1:0]         sh_i,
  input  logic                    shr_i,
  output logic [LANE_W*LANES-1:0] r_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] x;
    assign x = a_i[l*LANE_W +: LANE_W];
    assign r_o[l*LANE_W +: LANE_W] = shr_i ? (x >> sh_i) : (x << sh_i);
  end
endmodule

// File: rtl/vla_interleave.sv
module vla_interleave
  import vla_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input  logic [LANE_W*LANES-1:0] a_i,
  input  logic [LANE_W*LANES-1:0] b_i,
  input  logic [1:0]              esz_i,
  input  logic                    odd_i,
  output logic [LANE_W*LANES-1:0] r_o
);
  localparam int VEC_W = LANE_W * LANES;

  logic [VEC_W-1:0] even_r [NUM_ESZ];
  logic [VEC_W-1:0] odd_r  [NUM_ESZ];

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_size
    localparam int E    = LANE_W << g;
    localparam int HALF = VEC_W / E / 2;
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign even_r[g][(2*k)*E   +: E] = a_i[(2*k)*E   +: E];
      assign even_r[g][(2*k+1)*E +: E] = b_i[(2*k)*E   +: E];
      assign odd_r[g][(2*k)*E    +: E] = a_i[(2*k+1)*E +: E];
      assign odd_r[g][(2*k+1)*E  +: E] = b_i[(2*k+1)*E +: E];
    end
  end

  always_comb begin
    unique case (esz_i)
      2'd0:    r_o = odd_i ? odd_r[0] : even_r[0];
      2'd1:    r_o = odd_i ? odd_r[1] : even_r[1];
      default: r_o = odd_i ? odd_r[2] : even_r[2];
    endcase
  end
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import vla_pkg::*;
#(
  parameter int LANE_W = DEF_LANE_W,
  parameter int LANES  = DEF_LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [2:0]              op_i,
  input  logic [LANE_W*LANES-1:0] opa_i,
  input  logic [LANE_W*LANES-1:0] opb_i,
  input  logic [LANE_W-1:0]       mod_i,
  input  logic [$clog2(LANE_W)-1:0] shamt_i,
  input  logic                    shr_i,
  input  logic [1:0]              esz_i,
  output logic                    out_valid_o,
  output logic [LANE_W*LANES-1:0] res_o
);
  localparam int VEC_W = LANE_W * LANES;
  localparam int SH_W  = $clog2(LANE_W);

  vop_e op;
  assign op = vop_e'(op_i);

  logic [VEC_W-1:0]  gated_a, gated_b;
  logic [LANE_W-1:0] gated_q;
  logic [SH_W-1:0]   gated_sh;
  logic              gated_shr;
  logic [1:0]        gated_esz;

  vla_operand_gate #(.VEC_W(VEC_W), .LANE_W(LANE_W), .SH_W(SH_W)) u_gate (
    .valid_i (in_valid_i),
    .op_i    (op),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .q_i     (mod_i),
    .sh_i    (shamt_i),
    .shr_i   (shr_i),
    .esz_i   (esz_i),
    .a_o     (gated_a),
    .b_o     (gated_b),
    .q_o     (gated_q),
    .sh_o    (gated_sh),
    .shr_o   (gated_shr),
    .esz_o   (gated_esz)
  );

  logic [VEC_W-1:0] v_sum, v_diff, v_msum, v_mdiff, v_shift, v_trn;

  for (genvar l = 0; l < LANES; l++) begin : g_arith
    vla_lane_arith #(.W(LANE_W)) u_lane (
      .a_i     (gated_a[l*LANE_W +: LANE_W]),
      .b_i     (gated_b[l*LANE_W +: LANE_W]),
      .q_i     (gated_q),
      .sum_o   (v_sum[l*LANE_W +: LANE_W]),
      .diff_o  (v_diff[l*LANE_W +: LANE_W]),
      .msum_o  (v_msum[l*LANE_W +: LANE_W]),
      .mdiff_o (v_mdiff[l*LANE_W +: LANE_W])
    );
  end

  vla_lane_shift #(.LANE_W(LANE_W), .LANES(LANES), .SH_W(SH_W)) u_shift (
    .a_i   (gated_a),
    .sh_i  (gated_sh),
    .shr_i (gated_shr),
    .r_o   (v_shift)
  );

  vla_interleave #(.LANE_W(LANE_W), .LANES(LANES)) u_trn (
    .a_i   (gated_a),
    .b_i   (gated_b),
    .esz_i (gated_esz),
    .odd_i (op == OP_TRN2),
    .r_o   (v_trn)
  );

  logic [VEC_W-1:0] nxt_res;
  always_comb begin
    unique case (op)
      OP_ADD:            nxt_res = v_sum;
      OP_SUB:            nxt_res = v_diff;
      OP_ADDM:           nxt_res = v_msum;
      OP_SUBM:           nxt_res = v_mdiff;
      OP_SHV:            nxt_res = v_shift;
      OP_TRN1, OP_TRN2:  nxt_res = v_trn;
      default:           nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) res_o <= nxt_res;
    end
  end
endmodule

// File: rtl/vla_checker.sv
module vla_checker #(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [2:0]              op_i,
  input logic [LANE_W*LANES-1:0] opa_i,
  input logic [LANE_W*LANES-1:0] opb_i,
  input logic [LANE_W-1:0]       mod_i,
  input logic                    out_valid_o,
  input logic [LANE_W*LANES-1:0] res_o,
  input logic [LANE_W*LANES-1:0] gated_a,
  input logic [LANE_W*LANES-1:0] gated_b,
  input logic [LANE_W-1:0]       gated_q,
  input logic [$clog2(LANE_W)-1:0] gated_sh
);
  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_result_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_o));
  assert_none_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd7) |=> (res_o == '0));
  assert_idle_blank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> (gated_a == '0 && gated_b == '0 && gated_q == '0 && gated_sh == '0));
  assert_shift_blank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd4) |-> (gated_b == '0 && gated_q == '0));
  assert_plain_blank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i <= 3'd1) |-> (gated_q == '0 && gated_sh == '0));
  assert_add_lane0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd0) |=>
      (res_o[LANE_W-1:0] == $past(opa_i[LANE_W-1:0] + opb_i[LANE_W-1:0])));
  assert_modadd_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd2 && opa_i[LANE_W-1:0] < mod_i && opb_i[LANE_W-1:0] < mod_i)
      |=> (res_o[LANE_W-1:0] < $past(mod_i)));
  assert_modsub_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd3 && opa_i[LANE_W-1:0] < mod_i && opb_i[LANE_W-1:0] < mod_i)
      |=> (res_o[LANE_W-1:0] < $past(mod_i)));
endmodule

bind vec_lane_alu vla_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .mod_i       (mod_i),
  .out_valid_o (out_valid_o),
  .res_o       (res_o),
  .gated_a     (gated_a),
  .gated_b     (gated_b),
  .gated_q     (gated_q),
  .gated_sh    (gated_sh)
);

// File: tb/tb_vec_lane_alu.sv
`timescale 1ns/1ps
module tb_vec_lane_alu;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op;
  logic [255:0] opa, opb;
  logic [31:0]  modq;
  logic [4:0]   shamt;
  logic         shr;
  logic [1:0]   esz;
  logic         out_valid;
  logic [255:0] res;

  int n_checks = 0;
  int n_fail   = 0;
  logic         exp_vld = 1'b0;
  logic [255:0] exp_res = '0;

  always #4 clk = ~clk;

  vec_lane_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .mod_i(modq), .shamt_i(shamt), .shr_i(shr),
    .esz_i(esz), .out_valid_o(out_valid), .res_o(res)
  );

  // Behavioural reference: lane values as 64-bit integers, interleave by element index.
  function automatic logic [255:0] model(input logic [2:0] o, input logic [255:0] a,
      input logic [255:0] b, input logic [31:0] q, input logic [4:0] s, input logic rt,
      input logic [1:0] e);
    logic [255:0] r = '0;
    longint x, y, m, z;
    int el, cnt, src;
    m = longint'(q);
    if (o <= 3'd4) begin
      for (int i = 0; i < 8; i++) begin
        x = longint'(a[32*i +: 32]);
        y = longint'(b[32*i +: 32]);
        case (o)
          3'd0: z = x + y;
          3'd1: z = x - y;
          3'd2: begin z = x + y; if (z >= m) z = z - m; end
          3'd3: begin z = x - y; if (z < 0) z = z + m; end
          default: z = rt ? (x >> s) : (x << s);
        endcase
        z = z & 64'hFFFF_FFFF;
        r[32*i +: 32] = z[31:0];
      end
    end else if (o == 3'd5 || o == 3'd6) begin
      el  = (e == 2'd0) ? 32 : (e == 2'd1) ? 64 : 128;
      cnt = 256 / el;
      for (int i = 0; i < cnt; i++) begin
        src = (i / 2) * 2 + ((o == 3'd6) ? 1 : 0);
        for (int t = 0; t < el; t++)
          r[i*el + t] = (i % 2 == 0) ? a[src*el + t] : b[src*el + t];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (out_valid !== exp_vld || res !== exp_res) begin
      n_fail++;
      $display("FAIL %s valid=%0b/%0b actual=%h expected=%h", tag, out_valid, exp_vld,
               res, exp_res);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] o, input logic [255:0] a,
      input logic [255:0] b, input logic [31:0] q, input logic [4:0] s, input logic rt,
      input logic [1:0] e, input string tag);
    in_valid = v; op = o; opa = a; opb = b; modq = q; shamt = s; shr = rt; esz = e;
    exp_vld = v;
    if (v) exp_res = model(o, a, b, q, s, rt, e);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [255:0] rvec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] rvec_mod(input logic [31:0] q);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom % q;
    return v;
  endfunction

  function automatic logic [255:0] splat(input logic [31:0] x);
    return {8{x}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] a, b;
    logic [31:0]  q;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = rvec(); opb = rvec();
    modq = '1; shamt = '1; shr = 1'b1; esz = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    step(1'b0, 3'd0, rvec(), rvec(), $urandom, 5'd3, 1'b0, 2'd0, "R1 idle after reset");

    // R2: carry confined to lane; all-ones lane next to small lanes
    a = {32'd5, 32'hFFFF_FFFF, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF};
    b = splat(32'd1);
    step(1'b1, 3'd0, a, b, $urandom, $urandom, 1'b1, 2'd3, "R2 wrap add lanes");
    // R3: borrow confined
    step(1'b1, 3'd1, {8{32'd0}}, {32'd0, 32'd1, 32'd0, 32'd1, 32'd0, 32'd1, 32'd0, 32'd1},
         $urandom, $urandom, 1'b0, 2'd1, "R3 borrow lanes");
    // R4: sum exactly q, q-1, and 33-bit sums with q near 2^32
    q = 32'd8380417;
    step(1'b1, 3'd2, splat(32'd8380416), splat(32'd1), q, 5'd9, 1'b1, 2'd2, "R4 sum equals q");
    step(1'b1, 3'd2, splat(32'd8380415), splat(32'd1), q, 5'd0, 1'b0, 2'd0, "R4 sum below q");
    q = 32'hFFFF_FFFB;
    step(1'b1, 3'd2, splat(32'hFFFF_FFFA), splat(32'hFFFF_FFF0), q, 5'd1, 1'b0, 2'd0,
         "R4 carry-out reduction");
    step(1'b1, 3'd2, splat(32'h8000_0000), splat(32'h7FFF_FFFA), q, 5'd1, 1'b0, 2'd0,
         "R4 just below q near 2^32");
    // R5
    q = 32'd3329;
    step(1'b1, 3'd3, splat(32'd0), splat(32'd3328), q, 5'd4, 1'b1, 2'd1, "R5 negative diff");
    step(1'b1, 3'd3, splat(32'd3328), splat(32'd3328), q, 5'd4, 1'b1, 2'd1, "R5 zero diff");
    // R6: shifts, B and modulus garbage
    step(1'b1, 3'd4, splat(32'h8000_0001), rvec(), $urandom, 5'd31, 1'b1, 2'd2, "R6 right 31 logical");
    step(1'b1, 3'd4, splat(32'h8000_0001), rvec(), $urandom, 5'd31, 1'b0, 2'd1, "R6 left 31");
    step(1'b1, 3'd4, rvec(), rvec(), $urandom, 5'd0, 1'b1, 2'd0, "R6 zero count");
    // R7/R8/R9 every size code
    for (int e = 0; e < 4; e++) begin
      step(1'b1, 3'd5, rvec(), rvec(), $urandom, $urandom, 1'b1, e[1:0], "R7 R9 even interleave");
      step(1'b1, 3'd6, rvec(), rvec(), $urandom, $urandom, 1'b1, e[1:0], "R8 R9 odd interleave");
    end
    // R10: code 7 zero, hold while idle
    step(1'b1, 3'd7, rvec(), rvec(), $urandom, $urandom, 1'b1, 2'd1, "R10 code 7 zero");
    step(1'b1, 3'd0, rvec(), rvec(), $urandom, $urandom, 1'b0, 2'd0, "R10 result");
    step(1'b0, 3'd1, rvec(), rvec(), $urandom, $urandom, 1'b0, 2'd0, "R10 hold idle");
    step(1'b0, 3'd7, rvec(), rvec(), $urandom, $urandom, 1'b1, 2'd2, "R10 hold idle 2");

    // Random mix; unread inputs carry garbage (R11)
    for (int n = 0; n < 400; n++) begin
      logic [2:0] o;
      o = 3'($urandom % 8);
      case ($urandom % 3)
        0: q = 32'd8380417;
        1: q = 32'hFFFF_FFFB - ($urandom % 16);
        default: q = $urandom | 32'd1;
      endcase
      step(($urandom % 5) != 0, o, rvec_mod(q), rvec_mod(q), q, $urandom, $urandom,
           $urandom, "R11 random mix R2 R3 R4 R5 R6 R7 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule